// File: doc/BRIEF.md
# UART FIFO Ready-Pin Generator

This block drives the two active-low handshake pins of one UART channel. A DMA-style or block-transfer agent watches these pins to learn when receive data is waiting and when transmit space is free. The block does not store any characters. It reads the receive and transmit FIFO occupancy counts, the holding-register flags used while the FIFOs are off, a receive character time-out pulse, and three controls from the FIFO control register. From these it works out the level of each pin.

There are three pin behaviours, and the control bits choose one of them:

- **FIFOs off.** The pins follow the single holding registers.
- **Single-character mode.** The pins report whether any character is present in the FIFO.
- **Block-transfer mode.** The receive pin becomes a latch. It is armed when the trigger level is reached or a time-out occurs, and it is released only when the receive FIFO drains to empty. The transmit pin reports whether the transmit FIFO still has any free slot.

When the mode changes, both pins are forced inactive for one cycle and then re-evaluated.

Top module: `uart_rdy_pins`

## Requirements
- R1: While `rst` is high, both `rx_rdy_n` and `tx_rdy_n` are 1. The mode in force before the first cycle after reset is taken to be FIFOs off.
- R2: The mode is FIFOs off when `fifo_en`=0, whatever the value of `blk_mode`. It is single-character mode when `fifo_en`=1 and `blk_mode`=0, and block-transfer mode when `fifo_en`=1 and `blk_mode`=1.
- R3: On the cycle after the decoded mode differs from that of the previous cycle, both outputs are 1. The block-transfer receive latch is cleared at that point, and the outputs are evaluated normally from the next cycle on.
- R4: With FIFOs off, `rx_rdy_n` is the inverse of `rhr_full` and `tx_rdy_n` equals `thr_full`. Every output reflects the inputs sampled at the previous clock edge.
- R5: In single-character mode, `rx_rdy_n` is 0 exactly when `rx_count` ≥ 1, and `tx_rdy_n` is 0 exactly when `tx_count` = 0.
- R6: In block-transfer mode, `rx_rdy_n` falls to 0 once `rx_count` ≥ the trigger level. The trigger level is selected by `trig_sel`: 0→1, 1→4, 2→8 and 3→14 bytes.
- R7: In block-transfer mode, a `rx_timeout` pulse with `rx_count` ≥ 1 drives `rx_rdy_n` to 0 even when the count is below the trigger level.
- R8: In block-transfer mode, once `rx_rdy_n` is 0 it stays 0 while `rx_count` is nonzero, even when the count falls below the trigger level.
- R9: In block-transfer mode, `rx_rdy_n` returns to 1 when `rx_count` = 0. An empty FIFO takes priority over a time-out in the same cycle.
- R10: In block-transfer mode, `tx_rdy_n` is 0 while `tx_count` < 16 and 1 when `tx_count` ≥ 16 (full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable control bit |
| blk_mode | input | 1 | Block-transfer mode control bit |
| trig_sel | input | 2 | Receive trigger-level select |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_timeout | input | 1 | Receive character time-out pulse |
| rhr_full | input | 1 | Receive holding register holds a byte (FIFOs off) |
| thr_full | input | 1 | Transmit holding register holds a byte (FIFOs off) |
| rx_rdy_n | output | 1 | Active-low receive ready |
| tx_rdy_n | output | 1 | Active-low transmit ready |

## Verification
The only internal state is the registered previous mode and the block-transfer receive latch.

- **Wrong receive latch.** The fault shows on `rx_rdy_n` one cycle later. It appears either as a premature release while the FIFO still holds data during a descending-count sweep, or as a missed arming when the count crosses each of the four trigger levels.
- **Wrong stored mode.** The fault appears as a missing or spurious forced-high cycle on both pins right after a control-bit change.

The sweeps walk every occupancy value, so a wrong threshold or full comparison is exposed at the exact count where it first differs.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

  typedef enum logic [1:0] {
    RM_OFF   = 2'd0,
    RM_CHAR  = 2'd1,
    RM_BLOCK = 2'd2
  } rdy_mode_e;

endpackage

// File: rtl/rdy_mode_ctl.sv
module rdy_mode_ctl
  import uart_rdy_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fifo_en,
  input  logic      blk_mode,
  output rdy_mode_e mode,
  output logic      mode_chg
);

  rdy_mode_e mode_q;

  always_comb begin
    if (!fifo_en)      mode = RM_OFF;
    else if (blk_mode) mode = RM_BLOCK;
    else               mode = RM_CHAR;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RM_OFF;
    else     mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);

endmodule

// File: rtl/rdy_rx_gen.sv
module rdy_rx_gen
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  rdy_mode_e        mode,
  input  logic             mode_chg,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_timeout,
  input  logic             rhr_full,
  output logic             rx_rdy_n
);

  localparam int NLVL = 4;
  localparam int LVLS [NLVL] = '{TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3};

  logic [CNT_W-1:0] lvl_tab [NLVL];
  logic [CNT_W-1:0] trig;
  logic             empty, at_trig;
  logic             armed_q, armed_d;
  logic             rdy_n_d, rdy_n_q;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_tab[g] = CNT_W'(LVLS[g]);
  end

  assign trig    = lvl_tab[trig_sel];
  assign empty   = (rx_count == '0);
  assign at_trig = (rx_count >= trig);

  always_comb begin
    armed_d = armed_q;
    if (mode != RM_BLOCK || mode_chg) armed_d = 1'b0;
    else if (empty)                   armed_d = 1'b0;
    else if (at_trig || rx_timeout)   armed_d = 1'b1;
  end

  always_comb begin
    if (mode_chg) rdy_n_d = 1'b1;
    else begin
      unique case (mode)
        RM_OFF:   rdy_n_d = ~rhr_full;
        RM_CHAR:  rdy_n_d = empty;
        RM_BLOCK: rdy_n_d = ~armed_d;
        default:  rdy_n_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      rdy_n_q <= 1'b1;
    end else begin
      armed_q <= armed_d;
      rdy_n_q <= rdy_n_d;
    end
  end

  assign rx_rdy_n = rdy_n_q;

endmodule

// File: rtl/rdy_tx_gen.sv
module rdy_tx_gen
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  rdy_mode_e        mode,
  input  logic             mode_chg,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             thr_full,
  output logic             tx_rdy_n
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic full, empty;
  logic rdy_n_d, rdy_n_q;

  assign full  = (tx_count >= FULL_CNT);
  assign empty = (tx_count == '0);

  always_comb begin
    if (mode_chg) rdy_n_d = 1'b1;
    else begin
      unique case (mode)
        RM_OFF:   rdy_n_d = thr_full;
        RM_CHAR:  rdy_n_d = ~empty;
        RM_BLOCK: rdy_n_d = full;
        default:  rdy_n_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_n_q <= 1'b1;
    else     rdy_n_q <= rdy_n_d;
  end

  assign tx_rdy_n = rdy_n_q;

endmodule

// File: rtl/uart_rdy_pins.sv
module uart_rdy_pins
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             blk_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_timeout,
  input  logic             rhr_full,
  input  logic             thr_full,
  output logic             rx_rdy_n,
  output logic             tx_rdy_n
);

  rdy_mode_e mode;
  logic      mode_chg;

  rdy_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .blk_mode (blk_mode),
    .mode     (mode),
    .mode_chg (mode_chg)
  );

  rdy_rx_gen #(
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .TRIG_L0 (TRIG_L0),
    .TRIG_L1 (TRIG_L1),
    .TRIG_L2 (TRIG_L2),
    .TRIG_L3 (TRIG_L3)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .mode_chg   (mode_chg),
    .trig_sel   (trig_sel),
    .rx_count   (rx_count),
    .rx_timeout (rx_timeout),
    .rhr_full   (rhr_full),
    .rx_rdy_n   (rx_rdy_n)
  );

  rdy_tx_gen #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .mode_chg (mode_chg),
    .tx_count (tx_count),
    .thr_full (thr_full),
    .tx_rdy_n (tx_rdy_n)
  );

endmodule

// File: rtl/uart_rdy_chk.sv
module uart_rdy_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             blk_mode,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_timeout,
  input logic             rhr_full,
  input logic             thr_full,
  input logic             rx_rdy_n,
  input logic             tx_rdy_n
);

  logic [1:0] c_mode, c_prev;
  logic       steady, in_off, in_char, in_blk;

  assign c_mode  = {fifo_en & blk_mode, fifo_en & ~blk_mode};
  assign steady  = (c_mode == c_prev);
  assign in_off  = steady && (c_mode == 2'b00);
  assign in_char = steady && (c_mode == 2'b01);
  assign in_blk  = steady && (c_mode == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) c_prev <= 2'b00;
    else     c_prev <= c_mode;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_rdy_n && tx_rdy_n));

  p_mode_change_r3: assert property (@(posedge clk) disable iff (rst)
    !steady |=> (rx_rdy_n && tx_rdy_n));

  p_off_follow_r4: assert property (@(posedge clk) disable iff (rst)
    in_off |=> (rx_rdy_n == !$past(rhr_full)) && (tx_rdy_n == $past(thr_full)));

  p_char_rx_r5: assert property (@(posedge clk) disable iff (rst)
    in_char |=> (rx_rdy_n == ($past(rx_count) == '0)));

  p_timeout_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (in_blk && rx_timeout && rx_count != '0) |=> !rx_rdy_n);

  p_blk_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (in_blk && !rx_rdy_n && rx_count != '0) |=> !rx_rdy_n);

  p_blk_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (in_blk && rx_count == '0) |=> rx_rdy_n);

  p_blk_tx_full_r10: assert property (@(posedge clk) disable iff (rst)
    in_blk |=> (tx_rdy_n == ($past(tx_count) >= CNT_W'(DEPTH))));

endmodule

bind uart_rdy_pins uart_rdy_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en    (fifo_en),
  .blk_mode   (blk_mode),
  .rx_count   (rx_count),
  .tx_count   (tx_count),
  .rx_timeout (rx_timeout),
  .rhr_full   (rhr_full),
  .thr_full   (thr_full),
  .rx_rdy_n   (rx_rdy_n),
  .tx_rdy_n   (tx_rdy_n)
);

// File: tb/sim_uart_rdy_pins.sv
`timescale 1ns/1ps
module sim_uart_rdy_pins;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, blk_mode = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       rx_timeout = 1'b0, rhr_full = 1'b0, thr_full = 1'b0;
  logic       rx_rdy_n, tx_rdy_n;

  int checks = 0;
  int fails  = 0;
  int pm     = 0;
  bit ml     = 1'b0;

  always #2 clk = ~clk;

  uart_rdy_pins u0 (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .blk_mode   (blk_mode),
    .trig_sel   (trig_sel),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_timeout (rx_timeout),
    .rhr_full   (rhr_full),
    .thr_full   (thr_full),
    .rx_rdy_n   (rx_rdy_n),
    .tx_rdy_n   (tx_rdy_n)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int trig_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  task automatic apply(input bit fe, input bit bm, input int ts, input int rc, input int tc,
                       input bit to, input bit rh, input bit th,
                       input string rtag, input string ttag);
    int  m;
    bit  er, et;
    string rt, tt;
    @(negedge clk);
    fifo_en = fe; blk_mode = bm; trig_sel = 2'(ts);
    rx_count = 5'(rc); tx_count = 5'(tc);
    rx_timeout = to; rhr_full = rh; thr_full = th;
    m  = fe ? (bm ? 2 : 1) : 0;
    rt = rtag; tt = ttag;
    if (m != pm) begin
      er = 1'b1; et = 1'b1; ml = 1'b0; rt = "R3"; tt = "R3";
    end else if (m == 0) begin
      er = !rh; et = th;
    end else if (m == 1) begin
      er = (rc == 0); et = (tc != 0);
    end else begin
      if (rc == 0) ml = 1'b0;
      else if (rc >= trig_of(ts) || to) ml = 1'b1;
      er = !ml; et = (tc >= 16);
    end
    pm = m;
    @(posedge clk); #1;
    chk(rt, "rx_rdy_n", rx_rdy_n, er);
    chk(tt, "tx_rdy_n", tx_rdy_n, et);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: outputs inactive while reset is held
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rx_rdy_n in reset", rx_rdy_n, 1'b1);
    chk("R1", "tx_rdy_n in reset", tx_rdy_n, 1'b1);
    @(negedge clk); rst = 1'b0;
    apply(0, 0, 0, 0, 0, 0, 0, 1, "R1", "R1");

    // R4 and R2: FIFOs off, blk_mode toggled without effect
    for (int i = 0; i < 8; i++)
      apply(0, i[2], 0, 5, 5, 0, i[0], i[1], (i[2] ? "R2" : "R4"), (i[2] ? "R2" : "R4"));

    // R3 entering single-character mode, then R5 sweep
    apply(1, 0, 0, 3, 3, 0, 0, 0, "R3", "R3");
    for (int c = 0; c <= 16; c++) apply(1, 0, 0, c, 16 - c, 0, 0, 0, "R5", "R5");

    // R3 entering block mode with data already above trigger
    apply(1, 1, 0, 4, 0, 0, 0, 0, "R3", "R3");
    apply(1, 1, 0, 4, 0, 0, 0, 0, "R6", "R10");

    // R6 / R8 / R9 per trigger level
    for (int s = 0; s < 4; s++) begin
      apply(1, 1, s, 0, 0, 0, 0, 0, "R9", "R10");
      for (int c = 1; c <= 16; c++) apply(1, 1, s, c, 0, 0, 0, 0, "R6", "R10");
      for (int c = 15; c >= 1; c--) apply(1, 1, s, c, 0, 0, 0, 0, "R8", "R10");
      apply(1, 1, s, 0, 0, 0, 0, 0, "R9", "R10");
    end

    // R7: time-out below trigger, then R8 hold, R9 empty beats time-out
    apply(1, 1, 3, 2, 0, 0, 0, 0, "R6", "R10");
    apply(1, 1, 3, 2, 0, 1, 0, 0, "R7", "R10");
    apply(1, 1, 3, 1, 0, 0, 0, 0, "R8", "R10");
    apply(1, 1, 3, 0, 0, 1, 0, 0, "R9", "R10");
    apply(1, 1, 3, 0, 0, 0, 0, 0, "R9", "R10");

    // R10: transmit sweep
    for (int c = 0; c <= 16; c++) apply(1, 1, 0, 0, c, 0, 0, 0, "R9", "R10");

    // R3: mode change while armed clears the latch
    apply(1, 1, 1, 6, 2, 0, 0, 0, "R6", "R10");
    apply(1, 0, 1, 2, 2, 0, 0, 0, "R3", "R3");
    apply(1, 0, 1, 2, 2, 0, 0, 0, "R5", "R5");
    apply(1, 1, 1, 2, 2, 0, 0, 0, "R3", "R3");
    apply(1, 1, 1, 2, 2, 0, 0, 0, "R6", "R10");
    apply(0, 1, 1, 2, 2, 0, 1, 0, "R3", "R3");
    apply(0, 1, 1, 2, 2, 0, 1, 0, "R4", "R4");

    summary();
    $finish;
  end

endmodule